// File: doc/BRIEF.md
# Fine-grain thread picker

This block chooses, on every clock cycle, which one of four hardware threads sharing a single in-order pipeline gets the next fetch or issue slot. Each thread tells the picker whether it has work through a ready bit. The memory side tells the picker when a thread takes a cache miss and when that miss is filled.

A thread with an unfilled miss is skipped until its fill is reported. Among the remaining threads, the picker rotates round robin, so the granted thread can change on every cycle. The grant is a one-hot vector qualified by a valid bit. The search order starts just after the most recently granted thread.

The picker keeps one pending-miss flag per thread and one rotation pointer. A miss report is seen in the flag from the next cycle on. Eligibility is decided from the registered flags and the current ready bits.

Top module: `thread_picker`

## Requirements
- R1: After reset every pending-miss flag is clear and the rotation pointer is 0, so the first cycle with all threads ready grants thread 0 (grant vector 4'b0001, bit i is thread i).
- R2: When no thread is both ready and free of a pending miss, grantValid is 0 and grantOh is all zeros; otherwise grantValid is 1.
- R3: Whenever grantValid is 1, grantOh has exactly one bit set.
- R4: A granted thread has its ready bit set in the same cycle and has no pending miss.
- R5: The search begins at the pointer's thread and moves upward with wraparound (3 is followed by 0); the first eligible thread found is granted.
- R6: After a grant to thread i the pointer becomes (i+1) mod 4; in a cycle with no grant the pointer keeps its value.
- R7: A miss report for thread i sets its pending flag at the next clock edge, and thread i is not granted from the following cycle until the flag clears.
- R8: A fill report for thread i clears its pending flag at the next clock edge, making it eligible again from the following cycle.
- R9: A miss report and a fill report for the same thread in the same cycle leave that thread's pending flag set.
- R10: With all four threads ready and no pending misses, the grant moves to a different thread every cycle in the order 0, 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| threadReady | input | 4 | Per-thread ready bit; bit i is thread i |
| missReport | input | 4 | Per-thread cache miss report, one-cycle pulse |
| fillReport | input | 4 | Per-thread miss completion report, one-cycle pulse |
| grantOh | output | 4 | One-hot grant; bit i selects thread i |
| grantValid | output | 1 | High when a thread is granted this cycle |

## Verification
The checker tests several properties on every cycle. It checks that the grant is one-hot and qualified by valid. It checks that the grant is all zeros when valid is low. It checks that a granted thread is ready. It checks that a thread never receives the grant in the cycle right after its miss report, including when a fill arrives in the same cycle. The bench's scenarios cover the rest: the rotation order, the pointer holding across idle cycles, the release of a thread after its fill, and the reset starting point. These depend on history that only the bench's reference model tracks.

// File: rtl/tpick_pkg.sv
package tpick_pkg;
  parameter int unsigned THREADS = 4;
  localparam int unsigned IDX_W = (THREADS > 1) ? $clog2(THREADS) : 1;

  // strobes from the control half to the arbitration datapath
  typedef struct packed {
    logic [THREADS-1:0] eligMask;
    logic [IDX_W-1:0]   startIdx;
  } pickCtrl_t;
endpackage

// File: rtl/tpick_ctrl.sv
module tpick_ctrl
  import tpick_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [THREADS-1:0] threadReady,
  input  logic [THREADS-1:0] missReport,
  input  logic [THREADS-1:0] fillReport,
  input  logic               winValid,
  input  logic [IDX_W-1:0]   winIdx,
  output pickCtrl_t          ctrlOut
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(THREADS - 1);

  logic [THREADS-1:0] pendMiss;
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   nextPtr;

  // a miss that arrives with a fill wins, so the thread stays parked
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMiss <= '0;
      rrPtr    <= '0;
    end else begin
      pendMiss <= (pendMiss & ~fillReport) | missReport;
      if (winValid) rrPtr <= nextPtr;
    end
  end

  always_comb begin
    nextPtr = (winIdx == LAST_IDX) ? '0 : winIdx + 1'b1;
  end

  always_comb begin
    ctrlOut.eligMask = threadReady & ~pendMiss;
    ctrlOut.startIdx = rrPtr;
  end
endmodule

// File: rtl/tpick_dp.sv
module tpick_dp
  import tpick_pkg::*;
(
  input  pickCtrl_t          ctrlIn,
  output logic               winValid,
  output logic [IDX_W-1:0]   winIdx,
  output logic [THREADS-1:0] grantOh
);
  // walk forward from the pointer with wraparound; first eligible wins
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    for (int k = 0; k < int'(THREADS); k++) begin
      int cand;
      cand = (int'(ctrlIn.startIdx) + k) % int'(THREADS);
      if (!winValid && ctrlIn.eligMask[cand]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    grantOh = '0;
    if (winValid) grantOh[winIdx] = 1'b1;
  end
endmodule

// File: rtl/thread_picker.sv
module thread_picker
  import tpick_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [THREADS-1:0] threadReady,
  input  logic [THREADS-1:0] missReport,
  input  logic [THREADS-1:0] fillReport,
  output logic [THREADS-1:0] grantOh,
  output logic               grantValid
);
  pickCtrl_t          ctrlBus;
  logic [IDX_W-1:0]   winIdx;

  tpick_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .threadReady(threadReady),
    .missReport (missReport),
    .fillReport (fillReport),
    .winValid   (grantValid),
    .winIdx     (winIdx),
    .ctrlOut    (ctrlBus)
  );

  tpick_dp u_dp (
    .ctrlIn  (ctrlBus),
    .winValid(grantValid),
    .winIdx  (winIdx),
    .grantOh (grantOh)
  );
endmodule

// File: rtl/thread_picker_chk.sv
module thread_picker_chk
  import tpick_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [THREADS-1:0] threadReady,
  input logic [THREADS-1:0] missReport,
  input logic [THREADS-1:0] fillReport,
  input logic [THREADS-1:0] grantOh,
  input logic               grantValid
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $countones(grantOh) == 1);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> grantOh == '0);

  a_r4_ready_only: assert property (@(posedge clk) disable iff (!rstN)
    (grantOh & ~threadReady) == '0);

  a_r7_miss_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (|missReport) |=> (grantOh & $past(missReport)) == '0);

  a_r9_miss_beats_fill: assert property (@(posedge clk) disable iff (!rstN)
    (|(missReport & fillReport)) |=> (grantOh & $past(missReport & fillReport)) == '0);
endmodule

bind thread_picker thread_picker_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .threadReady(threadReady),
  .missReport (missReport),
  .fillReport (fillReport),
  .grantOh    (grantOh),
  .grantValid (grantValid)
);

// File: tb/thread_picker_bench.sv
`timescale 1ns/1ps
module thread_picker_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] threadReady = '0;
  logic [3:0] missReport = '0;
  logic [3:0] fillReport = '0;
  logic [3:0] grantOh;
  logic       grantValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference model state
  bit [3:0] mPend = '0;
  int       mPtr  = 0;

  always #2.5 clk = ~clk;

  thread_picker u_thread_picker (
    .clk(clk), .rstN(rstN), .threadReady(threadReady),
    .missReport(missReport), .fillReport(fillReport),
    .grantOh(grantOh), .grantValid(grantValid)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive one cycle, compare against the model, advance the model
  task automatic step(input logic [3:0] rdy, input logic [3:0] miss,
                      input logic [3:0] fill, input string tag);
    bit       found;
    int       win;
    bit [3:0] expG;
    @(negedge clk);
    threadReady = rdy; missReport = miss; fillReport = fill;
    #1;
    found = 0; win = 0;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (mPtr + k) % 4;
      if (!found && rdy[c] && !mPend[c]) begin found = 1; win = c; end
    end
    expG = found ? (4'b0001 << win) : 4'b0000;
    check(found ? tag : "R2", {grantValid, grantOh}, {found, expG});
    check("R3", 5'($countones(grantOh) == (grantValid ? 1 : 0)), 5'd1);
    check("R4", {1'b0, grantOh & ~rdy}, 5'd0);
    mPend = (mPend & ~fill) | miss;
    if (found) mPtr = (win + 1) % 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {grantValid, grantOh}, 5'b0);
    rstN = 1'b1;
    // R1: first all-ready cycle grants thread 0
    step(4'hF, 4'h0, 4'h0, "R1");
    // R10: steady rotation
    repeat (7) step(4'hF, 4'h0, 4'h0, "R10");
    // R6: pointer holds over idle cycles, then resumes
    step(4'b0100, 4'h0, 4'h0, "R6");
    repeat (3) step(4'h0, 4'h0, 4'h0, "R6");
    repeat (3) step(4'hF, 4'h0, 4'h0, "R6");
    // R5: sparse ready patterns exercise wraparound search
    step(4'b1001, 4'h0, 4'h0, "R5");
    step(4'b1001, 4'h0, 4'h0, "R5");
    step(4'b0110, 4'h0, 4'h0, "R5");
    // R7: thread 1 misses and is skipped
    step(4'hF, 4'b0010, 4'h0, "R7");
    repeat (6) step(4'hF, 4'h0, 4'h0, "R7");
    step(4'b0010, 4'h0, 4'h0, "R7");
    // R8: fill releases thread 1
    step(4'hF, 4'h0, 4'b0010, "R8");
    repeat (4) step(4'b0010, 4'h0, 4'h0, "R8");
    // R9: miss and fill together keep thread 2 parked
    step(4'hF, 4'b0100, 4'h0, "R9");
    step(4'hF, 4'b0100, 4'b0100, "R9");
    repeat (4) step(4'b0100, 4'h0, 4'h0, "R9");
    step(4'hF, 4'h0, 4'b0100, "R9");
    repeat (2) step(4'b0100, 4'h0, 4'h0, "R8");
    // R2: every thread parked on a miss
    step(4'hF, 4'hF, 4'h0, "R2");
    repeat (3) step(4'hF, 4'h0, 4'h0, "R2");
    step(4'hF, 4'h0, 4'hF, "R8");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r, m, f;
      r = 4'($urandom);
      m = (($urandom % 6) == 0) ? 4'($urandom) & 4'($urandom) : 4'h0;
      f = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      step(r, m, f, "R5");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule